// File: doc/BRIEF.md
# Frame Counter Restart Scheduler

This block times the restart of an audio frame counter that lives on a clock running at half the CPU rate. Every audio cycle is two CPU cycles: a read-phase cycle followed by a write-phase cycle. The block generates this phase internally, starting from reset, so the first CPU cycle after reset is always a read phase. The counter may only advance or restart during a write-phase cycle.

A CPU write to the frame-counter control register is held in a latch until it can be transferred. The restart pulse then fires on the first write-phase cycle after the cycle in which the write strobe was sampled. This gives a latency of one CPU cycle for a write in a read-phase cycle and two CPU cycles for a write in a write-phase cycle. A restart is never immediate.

On a restart the counter value clears and the two mode bits are loaded. On every other write-phase cycle a count pulse fires and the counter advances by one. The write port is a plain register strobe with no back-pressure. The block always accepts the write, and a later write that arrives before the restart replaces the held value.

Top module: `frame_restart_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `restart_o`, `count_o`, `cnt_o` and `mode_o` are all zero and `phase_o` is 0 (read phase).
- R2: `phase_o` alternates every CPU cycle. The value 0 marks a read-phase cycle and 1 marks a write-phase cycle, and the first cycle after reset is a read phase.
- R3: A write strobe sampled at the end of a read-phase cycle makes `restart_o` high in the very next cycle, which is a write-phase cycle.
- R4: A write strobe sampled at the end of a write-phase cycle leaves `restart_o` low in the next cycle (read phase) and makes it high in the cycle after that.
- R5: `restart_o` is high only in write-phase cycles and never for two consecutive cycles.
- R6: `count_o` is high in every write-phase cycle that carries no restart, and it is never high in a read-phase cycle.
- R7: Restart takes priority over counting: `count_o` is low in a restart cycle and the counter does not advance there.
- R8: `cnt_o` reads 0 in a restart cycle, rises by one in each count cycle (modulo 2^CNT_W), and holds otherwise.
- R9: In a restart cycle, `mode_o[1]` takes data bit 7 and `mode_o[0]` takes data bit 6 of the write that caused it. The remaining data bits have no effect, and `mode_o` holds between restarts.
- R10: Several writes before one restart produce a single restart pulse, and the mode bits come from the latest of those writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-register write strobe, one per CPU cycle |
| wr_data | input | 8 | Write data; bits 7 and 6 carry the mode |
| phase_o | output | 1 | Current audio phase: 0 read, 1 write |
| restart_o | output | 1 | One-cycle frame-counter restart |
| count_o | output | 1 | Count-enable pulse |
| mode_o | output | 2 | Latched mode bits |
| cnt_o | output | CNT_W | Frame counter value |

## Verification
All outputs are registered. A strobe sampled at a clock edge shows its effect during the cycle that edge opens: `restart_o`, `cnt_o` and `mode_o` change in the next cycle after a read-phase write, and two cycles later after a write-phase write. The bench drives inputs and samples outputs on the falling edge. It keeps a cycle-level expectation that is built only from the phase parity and the pending-write rules, and it checks every output against that expectation in each cycle. Write masks are swept over windows of six cycles at both phase offsets, so single, back-to-back and spaced writes meet both latencies, and a long idle run checks the counter wrap.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } frc_phase_e;

  localparam int MODE_W   = 2;
  localparam int DATA_W   = 8;
  localparam int MODE_MSB = 7;
endpackage

// File: rtl/frc_phase_gen.sv
module frc_phase_gen
  import frc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output frc_phase_e phase_q,
  output logic       next_is_write
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_READ;
    else        phase_q <= (phase_q == PH_READ) ? PH_WRITE : PH_READ;
  end

  assign next_is_write = (phase_q == PH_READ);
endmodule

// File: rtl/frc_write_hold.sv
module frc_write_hold
  import frc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              next_is_write,
  output logic              fire,
  output logic [MODE_W-1:0] fire_mode
);
  logic              pend_q;
  logic [MODE_W-1:0] held_q;
  logic [MODE_W-1:0] wr_mode;

  for (genvar i = 0; i < MODE_W; i++) begin : g_mode
    assign wr_mode[i] = wr_data[MODE_MSB - (MODE_W - 1) + i];
  end

  assign fire      = next_is_write && (pend_q || wr_en);
  assign fire_mode = wr_en ? wr_mode : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      held_q <= '0;
    end else begin
      pend_q <= next_is_write ? 1'b0 : (pend_q || wr_en);
      if (wr_en) held_q <= wr_mode;
    end
  end
endmodule

// File: rtl/frc_counter.sv
module frc_counter
  import frc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              next_is_write,
  input  logic              fire,
  input  logic [MODE_W-1:0] fire_mode,
  output logic              restart_q,
  output logic              count_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic do_count;

  assign do_count = next_is_write && !fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      count_q   <= 1'b0;
      mode_q    <= '0;
      cnt_q     <= '0;
    end else begin
      restart_q <= fire;
      count_q   <= do_count;
      if (fire) begin
        mode_q <= fire_mode;
        cnt_q  <= '0;
      end else if (do_count) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_restart_ctl.sv
module frame_restart_ctl
  import frc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             phase_o,
  output logic             restart_o,
  output logic             count_o,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] cnt_o
);
  frc_phase_e        phase_q;
  logic              next_is_write;
  logic              fire;
  logic [MODE_W-1:0] fire_mode;

  frc_phase_gen u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_q       (phase_q),
    .next_is_write (next_is_write)
  );

  frc_write_hold u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .next_is_write (next_is_write),
    .fire          (fire),
    .fire_mode     (fire_mode)
  );

  frc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .next_is_write (next_is_write),
    .fire          (fire),
    .fire_mode     (fire_mode),
    .restart_q     (restart_o),
    .count_q       (count_o),
    .mode_q        (mode_o),
    .cnt_q         (cnt_o)
  );

  assign phase_o = (phase_q == PH_WRITE);
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             phase_o,
  input logic             restart_o,
  input logic             count_o,
  input logic [1:0]       mode_o,
  input logic [CNT_W-1:0] cnt_o
);
  AST_PHASE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o |=> phase_o); // R2
  AST_PHASE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o |=> !phase_o); // R2
  AST_READ_WRITE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !phase_o) |=> restart_o); // R3
  AST_WRITE_WRITE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && phase_o) |=> (!restart_o ##1 restart_o)); // R4
  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> phase_o); // R5
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o); // R5
  AST_COUNT_EVERY_WPH: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o |-> (count_o || restart_o)); // R6
  AST_NO_COUNT_RPH: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o |-> !count_o); // R6
  AST_RESTART_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_o && count_o)); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (cnt_o == '0)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    count_o |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_o |=> (restart_o || $stable(mode_o))); // R9
endmodule

bind frame_restart_ctl frc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .phase_o   (phase_o),
  .restart_o (restart_o),
  .count_o   (count_o),
  .mode_o    (mode_o),
  .cnt_o     (cnt_o)
);

// File: tb/sim_frame_restart_ctl.sv
`timescale 1ns/1ps
module sim_frame_restart_ctl;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             phase_o, restart_o, count_o;
  logic [1:0]       mode_o;
  logic [CNT_W-1:0] cnt_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // expected state
  bit             e_ph, e_rs, e_ct, pend;
  bit [1:0]       e_mode, p_mode;
  bit [CNT_W-1:0] e_cnt;
  int             cyc, last_wr_cyc, last_wr_ph;

  always #2.5 clk = ~clk;

  frame_restart_ctl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .phase_o(phase_o), .restart_o(restart_o), .count_o(count_o),
    .mode_o(mode_o), .cnt_o(cnt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    chk(phase_o == e_ph, "R2 phase", phase_o, e_ph);
    chk(restart_o == e_rs, "R3/R4/R5/R10 restart", restart_o, e_rs);
    chk(count_o == e_ct, "R6/R7 count", count_o, e_ct);
    chk(cnt_o == e_cnt, "R8 counter", cnt_o, e_cnt);
    chk(mode_o == e_mode, "R9 mode", mode_o, e_mode);
    if (restart_o && last_wr_cyc >= 0) begin
      // latency from the latest write: 1 after read phase, 2 after write phase
      if (last_wr_ph == 0)
        chk(cyc - last_wr_cyc == 1, "R3 latency", cyc - last_wr_cyc, 1);
      else if (cyc - last_wr_cyc <= 2)
        chk(cyc - last_wr_cyc == 2, "R4 latency", cyc - last_wr_cyc, 2);
    end
  endtask

  // drive one cycle (called at negedge after checks), advance expectation
  task automatic step(input bit w, input bit [7:0] d);
    bit nph, fire;
    bit [1:0] m;
    wr_en   = w;
    wr_data = d;
    m = {d[7], d[6]};
    if (w) begin last_wr_cyc = cyc; last_wr_ph = e_ph; end
    nph  = !e_ph;
    fire = nph && (pend || w);
    if (fire) e_mode = w ? m : p_mode;
    if (w) p_mode = m;
    pend = nph ? 1'b0 : (pend || w);
    e_rs = fire;
    e_ct = nph && !fire;
    if (fire) e_cnt = '0;
    else if (e_ct) e_cnt = e_cnt + 1'b1;
    e_ph = nph;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check_all();
  endtask

  initial begin
    e_ph = 0; e_rs = 0; e_ct = 0; pend = 0; e_mode = 0; p_mode = 0; e_cnt = 0;
    cyc = 0; last_wr_cyc = -100; last_wr_ph = 0;
    repeat (3) @(negedge clk);
    // R1: reset state while held, with write strobe active
    wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    chk(!restart_o && !count_o && cnt_o == 0 && mode_o == 0 && !phase_o,
        "R1 reset", {restart_o, count_o, mode_o, phase_o}, 0);
    wr_en = 1'b0; wr_data = '0;
    rst_n = 1'b1;
    check_all(); // R1 first cycle after reset
    // sweep 6-cycle write masks at both phase offsets
    for (int off = 0; off < 2; off++) begin
      if (off == 1) step(1'b0, 8'h00);
      for (int p = 0; p < 64; p++) begin
        for (int j = 0; j < 6; j++)
          step(p[j], 8'((p * 37 + j * 11 + off * 5 + 3) & 8'hFF));
        for (int k = 0; k < 4; k++) step(1'b0, 8'hC0);
      end
    end
    // long idle run: counter wrap (R8)
    for (int k = 0; k < 40; k++) step(1'b0, 8'h3F);
    // R9: only bits 7 and 6 matter
    step(1'b1, 8'h7F);
    for (int k = 0; k < 4; k++) step(1'b0, 8'h00);
    step(1'b1, 8'h80);
    for (int k = 0; k < 4; k++) step(1'b0, 8'h00);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule